// File: doc/BRIEF.md
# Shift, Logic and Bit-Test Unit

This block is the non-arithmetic execution slice of an accumulator machine. Every operation takes one clock. It performs bitwise AND, OR and XOR of the accumulator with a memory operand. It performs single-bit shifts and rotates through carry, increment and decrement, and a bit-test that reports operand bits through the flags. It also performs test-and-set and test-and-reset of memory bits. Each operation runs at the full 16-bit width or in a narrow 8-bit mode. In narrow mode only the low byte takes part.

The caller sets up the operation code, the width, the form select, the accumulator value, the memory operand and the incoming carry, and raises `op_valid` for one cycle. One clock later the unit presents:
- the result, with a one-cycle `done` pulse;
- one of two destination strobes: accumulator update, or write-back to the memory operand's address;
- a per-flag write mask and the flag values;
- a marker that the operation costs one extra internal cycle.

Operations may be issued on consecutive cycles. Address generation and the bus are handled elsewhere.

Top module: `shift_logic_unit`

## Requirements
- R1: An operation sampled with `op_valid` high on a rising edge raises `done` for exactly the following cycle. `done` is low after any edge at which `op_valid` was low.
- R2: The operation codes are 0 AND, 1 OR, 2 XOR. Each combines the accumulator with `mem_in` and writes the accumulator. Only N and Z are written, both taken from the result. Flag bit order on `flags` and `flags_we` is N=3, V=2, Z=1, C=0. Z is 1 when its source is zero.
- R3: Code 3 shifts left: the old MSB goes to C and 0 enters at the LSB. Code 4 shifts right: the old LSB goes to C and 0 enters at the MSB. Both write N, Z and C.
- R4: Code 5 rotates left: `carry_in` enters at the LSB and the old MSB goes to C. Code 6 rotates right: `carry_in` enters at the MSB and the old LSB goes to C. Both write N, Z and C.
- R5: Code 7 increments and code 8 decrements, both modulo 2^width. Only N and Z are written; C is never written.
- R6: For codes 3 to 8, `to_mem`=1 selects the memory form. In that form the operand is `mem_in` and `wb_en` is high for the one result cycle. Otherwise the operand is `acc_in` and `acc_we` is high. `acc_we` and `wb_en` are never high together.
- R7: Code 9 (bit-test) writes neither destination and leaves `result` equal to `acc_in`. It writes N from the operand MSB and V from the bit below the MSB (bit 14 wide, bit 6 narrow). It writes Z from (`mem_in` AND `acc_in`) == 0.
- R8: Code 10 writes back `mem_in` OR `acc_in`. Code 11 writes back `mem_in` AND NOT `acc_in`. Both write only Z, taken from (`mem_in` AND `acc_in`) == 0 before modification, and both always use the memory destination.
- R9: `extra_cycle` is high with `done` for codes 3 to 8, 10 and 11, in either form. It is low for every other code.
- R10: With `narrow`=1 each operation works on the low 8 bits. An accumulator-destination result keeps bits 15:8 of `acc_in`. A memory-destination result has bits 15:8 zero.
- R11: During and right after reset, `done`, `acc_we`, `wb_en`, `flags_we`, `flags`, `extra_cycle` and `result` are all zero.
- R12: Codes 12 to 15 pulse `done`, write no destination and no flag, and leave `result` equal to `acc_in`. Flag bits not written by an operation read as 0 on `flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code |
| narrow | input | 1 | 1 = 8-bit operation |
| to_mem | input | 1 | 1 = memory form of shift/rotate/inc/dec |
| acc_in | input | DATA_W | Accumulator value |
| mem_in | input | DATA_W | Memory operand |
| carry_in | input | 1 | Current carry flag |
| result | output | DATA_W | Value for the selected destination |
| done | output | 1 | Result cycle pulse |
| acc_we | output | 1 | Accumulator update strobe |
| wb_en | output | 1 | Memory write-back strobe |
| flags_we | output | 4 | Per-flag write mask (N,V,Z,C) |
| flags | output | 4 | Flag values (N,V,Z,C) |
| extra_cycle | output | 1 | Operation needs one extra internal cycle |

## Verification
Every output belonging to an operation is due in the cycle right after the rising edge that samples `op_valid`. The bench drives inputs on the falling edge. A behavioural model computes the expected outputs at once and queues them. At the next falling edge, after exactly one register stage, the bench pops that expectation and compares it with every output. Idle cycles queue an expectation too: no strobes and a held result. Missing or stray pulses are therefore caught in the cycle they occur.

// File: rtl/slu_pkg.sv
package slu_pkg;

   typedef enum logic [3:0] {
      OP_AND  = 4'd0,
      OP_OR   = 4'd1,
      OP_XOR  = 4'd2,
      OP_SHL  = 4'd3,
      OP_SHR  = 4'd4,
      OP_ROL  = 4'd5,
      OP_ROR  = 4'd6,
      OP_INC  = 4'd7,
      OP_DEC  = 4'd8,
      OP_BIT  = 4'd9,
      OP_TSET = 4'd10,
      OP_TCLR = 4'd11
   } slu_op_e;

   localparam int FLG_N = 3;
   localparam int FLG_V = 2;
   localparam int FLG_Z = 1;
   localparam int FLG_C = 0;

   function automatic logic op_is_logic(logic [3:0] op);
      return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
   endfunction

   function automatic logic op_is_shift(logic [3:0] op);
      return (op >= OP_SHL) && (op <= OP_DEC);
   endfunction

   function automatic logic op_is_test(logic [3:0] op);
      return (op == OP_TSET) || (op == OP_TCLR);
   endfunction

   function automatic logic op_has_extra(logic [3:0] op);
      return op_is_shift(op) || op_is_test(op);
   endfunction

   function automatic logic [3:0] op_flag_mask(logic [3:0] op);
      logic [3:0] m;
      m = 4'b0000;
      case (op)
         OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: m = 4'b1010;
         OP_SHL, OP_SHR, OP_ROL, OP_ROR:        m = 4'b1011;
         OP_BIT:                                m = 4'b1110;
         OP_TSET, OP_TCLR:                      m = 4'b0010;
         default:                               m = 4'b0000;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/slu_logic_lane.sv
module slu_logic_lane
   import slu_pkg::*;
#(
   parameter int LW = 16
) (
   input  logic [3:0]    op,
   input  logic [LW-1:0] acc,
   input  logic [LW-1:0] mem,
   output logic [LW-1:0] val,
   output logic [3:0]    flg
);

   generate
      if (LW < 2) begin : g_bad_width
         $error("slu_logic_lane: LW must be at least 2");
      end
   endgenerate

   logic [LW-1:0] overlap;
   logic          overlap_zero;

   assign overlap      = acc & mem;
   assign overlap_zero = (overlap == '0);

   always_comb begin
      case (op)
         OP_AND:  val = overlap;
         OP_OR:   val = acc | mem;
         OP_XOR:  val = acc ^ mem;
         OP_TSET: val = mem | acc;
         OP_TCLR: val = mem & ~acc;
         default: val = acc;
      endcase
   end

   always_comb begin
      flg        = 4'b0000;
      flg[FLG_N] = val[LW-1];
      flg[FLG_Z] = (val == '0);
      if (op == OP_BIT) begin
         flg[FLG_N] = mem[LW-1];
         flg[FLG_V] = mem[LW-2];
         flg[FLG_Z] = overlap_zero;
      end else if (op_is_test(op)) begin
         flg[FLG_Z] = overlap_zero;
      end
   end

endmodule

// File: rtl/slu_shift_lane.sv
module slu_shift_lane
   import slu_pkg::*;
#(
   parameter int LW = 16
) (
   input  logic [3:0]    op,
   input  logic [LW-1:0] src,
   input  logic          cin,
   output logic [LW-1:0] val,
   output logic [3:0]    flg
);

   generate
      if (LW < 2) begin : g_bad_width
         $error("slu_shift_lane: LW must be at least 2");
      end
   endgenerate

   localparam logic [LW-1:0] ONE = {{(LW-1){1'b0}}, 1'b1};

   logic cout;

   always_comb begin
      cout = 1'b0;
      case (op)
         OP_SHL: begin
            val  = {src[LW-2:0], 1'b0};
            cout = src[LW-1];
         end
         OP_SHR: begin
            val  = {1'b0, src[LW-1:1]};
            cout = src[0];
         end
         OP_ROL: begin
            val  = {src[LW-2:0], cin};
            cout = src[LW-1];
         end
         OP_ROR: begin
            val  = {cin, src[LW-1:1]};
            cout = src[0];
         end
         OP_INC:  val = src + ONE;
         OP_DEC:  val = src - ONE;
         default: val = src;
      endcase
   end

   always_comb begin
      flg        = 4'b0000;
      flg[FLG_N] = val[LW-1];
      flg[FLG_Z] = (val == '0);
      flg[FLG_C] = cout;
   end

endmodule

// File: rtl/shift_logic_unit.sv
module shift_logic_unit
   import slu_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit ALLOW_NARROW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic              narrow,
   input  logic              to_mem,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] mem_in,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result,
   output logic              done,
   output logic              acc_we,
   output logic              wb_en,
   output logic [3:0]        flags_we,
   output logic [3:0]        flags,
   output logic              extra_cycle
);

   localparam int HALF_W = DATA_W / 2;

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("shift_logic_unit: DATA_W must be even and at least 4");
      end
   endgenerate

   // operation class decode
   logic use_shift;
   logic dest_acc;
   logic dest_mem;
   logic [3:0] flag_mask;

   assign use_shift = op_is_shift(op_code);
   assign dest_mem  = (use_shift && to_mem) || op_is_test(op_code);
   assign dest_acc  = op_is_logic(op_code) || (use_shift && !to_mem);
   assign flag_mask = op_flag_mask(op_code);

   // full-width lanes
   logic [DATA_W-1:0] shift_src;
   logic [DATA_W-1:0] lg_val_w, sh_val_w, val_w;
   logic [3:0]        lg_flg_w, sh_flg_w, flg_w;

   assign shift_src = to_mem ? mem_in : acc_in;

   slu_logic_lane #(.LW(DATA_W)) u_logic_wide (
      .op  (op_code),
      .acc (acc_in),
      .mem (mem_in),
      .val (lg_val_w),
      .flg (lg_flg_w)
   );

   slu_shift_lane #(.LW(DATA_W)) u_shift_wide (
      .op  (op_code),
      .src (shift_src),
      .cin (carry_in),
      .val (sh_val_w),
      .flg (sh_flg_w)
   );

   assign val_w = use_shift ? sh_val_w : lg_val_w;
   assign flg_w = use_shift ? sh_flg_w : lg_flg_w;

   // half-width lanes, present only when narrow mode is built in
   logic [HALF_W-1:0] val_n;
   logic [3:0]        flg_n;
   logic              eff_narrow;

   generate
      if (ALLOW_NARROW) begin : g_narrow
         logic [HALF_W-1:0] lg_val_n, sh_val_n;
         logic [3:0]        lg_flg_n, sh_flg_n;

         slu_logic_lane #(.LW(HALF_W)) u_logic_narrow (
            .op  (op_code),
            .acc (acc_in[HALF_W-1:0]),
            .mem (mem_in[HALF_W-1:0]),
            .val (lg_val_n),
            .flg (lg_flg_n)
         );

         slu_shift_lane #(.LW(HALF_W)) u_shift_narrow (
            .op  (op_code),
            .src (shift_src[HALF_W-1:0]),
            .cin (carry_in),
            .val (sh_val_n),
            .flg (sh_flg_n)
         );

         assign val_n      = use_shift ? sh_val_n : lg_val_n;
         assign flg_n      = use_shift ? sh_flg_n : lg_flg_n;
         assign eff_narrow = narrow;
      end else begin : g_wide_only
         assign val_n      = '0;
         assign flg_n      = 4'b0000;
         assign eff_narrow = 1'b0;
      end
   endgenerate

   // merge lanes into the next result
   logic [DATA_W-1:0] nxt_res;
   logic [3:0]        nxt_flg;

   always_comb begin
      nxt_res = acc_in;
      nxt_flg = flg_w;
      if (eff_narrow) begin
         nxt_flg = flg_n;
         if (dest_acc) begin
            nxt_res = {acc_in[DATA_W-1:HALF_W], val_n};
         end else if (dest_mem) begin
            nxt_res = {{(DATA_W-HALF_W){1'b0}}, val_n};
         end
      end else if (dest_acc || dest_mem) begin
         nxt_res = val_w;
      end
   end

   // single output register stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result      <= '0;
         done        <= 1'b0;
         acc_we      <= 1'b0;
         wb_en       <= 1'b0;
         flags_we    <= 4'b0000;
         flags       <= 4'b0000;
         extra_cycle <= 1'b0;
      end else begin
         done        <= op_valid;
         acc_we      <= op_valid && dest_acc;
         wb_en       <= op_valid && dest_mem;
         flags_we    <= op_valid ? flag_mask : 4'b0000;
         flags       <= op_valid ? (nxt_flg & flag_mask) : 4'b0000;
         extra_cycle <= op_valid && op_has_extra(op_code);
         if (op_valid) begin
            result <= nxt_res;
         end
      end
   end

endmodule

// File: rtl/slu_checker.sv
module slu_checker
   import slu_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit ALLOW_NARROW = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [3:0]        op_code,
   input logic              narrow,
   input logic              to_mem,
   input logic [DATA_W-1:0] acc_in,
   input logic [DATA_W-1:0] mem_in,
   input logic              carry_in,
   input logic [DATA_W-1:0] result,
   input logic              done,
   input logic              acc_we,
   input logic              wb_en,
   input logic [3:0]        flags_we,
   input logic [3:0]        flags,
   input logic              extra_cycle
);

   localparam int HALF_W = DATA_W / 2;

   assert_done_after_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> done);

   assert_no_stray_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !done);

   assert_logic_nz_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code <= 4'd2)) |=> (acc_we && flags_we == 4'b1010));

   assert_shl_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'd3 && !narrow && !to_mem)
      |=> (flags_we[FLG_C] && flags[FLG_C] == $past(acc_in[DATA_W-1])));

   assert_ror_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'd6 && !narrow && !to_mem)
      |=> (result[DATA_W-1] == $past(carry_in) && flags[FLG_C] == $past(acc_in[0])));

   assert_incdec_keeps_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == 4'd7 || op_code == 4'd8)) |=> !flags_we[FLG_C]);

   assert_single_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_we && wb_en));

   assert_wb_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> done);

   assert_bit_no_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 4'd9)
      |=> (!acc_we && !wb_en && flags_we == 4'b1110 && result == $past(acc_in)));

   assert_test_ops_z_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == 4'd10 || op_code == 4'd11)) |=> (wb_en && flags_we == 4'b0010));

   assert_extra_marks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      extra_cycle |-> done);

   assert_no_extra_for_logic_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code <= 4'd2 || op_code == 4'd9)) |=> !extra_cycle);

   assert_unknown_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code >= 4'd12) |=> (done && !acc_we && !wb_en && flags_we == 4'b0000));

   generate
      if (ALLOW_NARROW) begin : g_narrow_chk
         assert_narrow_keeps_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && narrow && op_code <= 4'd2)
            |=> (result[DATA_W-1:HALF_W] == $past(acc_in[DATA_W-1:HALF_W])));
      end
   endgenerate

endmodule

bind shift_logic_unit slu_checker #(
   .DATA_W       (DATA_W),
   .ALLOW_NARROW (ALLOW_NARROW)
) u_slu_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_valid    (op_valid),
   .op_code     (op_code),
   .narrow      (narrow),
   .to_mem      (to_mem),
   .acc_in      (acc_in),
   .mem_in      (mem_in),
   .carry_in    (carry_in),
   .result      (result),
   .done        (done),
   .acc_we      (acc_we),
   .wb_en       (wb_en),
   .flags_we    (flags_we),
   .flags       (flags),
   .extra_cycle (extra_cycle)
);

// File: tb/shift_logic_unit_test.sv
module shift_logic_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = 4'd0;
   logic        narrow = 1'b0;
   logic        to_mem = 1'b0;
   logic [15:0] acc_in = 16'h0;
   logic [15:0] mem_in = 16'h0;
   logic        carry_in = 1'b0;
   logic [15:0] result;
   logic        done, acc_we, wb_en, extra_cycle;
   logic [3:0]  flags_we, flags;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   shift_logic_unit #(.DATA_W(16), .ALLOW_NARROW(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .narrow(narrow), .to_mem(to_mem), .acc_in(acc_in), .mem_in(mem_in),
      .carry_in(carry_in), .result(result), .done(done), .acc_we(acc_we),
      .wb_en(wb_en), .flags_we(flags_we), .flags(flags), .extra_cycle(extra_cycle)
   );

   typedef struct packed {
      logic [15:0] res;
      logic        dn;
      logic        aw;
      logic        mw;
      logic [3:0]  fwe;
      logic [3:0]  fl;
      logic        xc;
      logic [3:0]  op;
      logic        nar;
   } exp_t;

   exp_t        pending[$];
   logic [15:0] last_res = 16'h0;

   function automatic string op_tag(logic [3:0] op);
      if (op <= 4'd2) return "R2";
      if (op == 4'd3 || op == 4'd4) return "R3";
      if (op == 4'd5 || op == 4'd6) return "R4";
      if (op == 4'd7 || op == 4'd8) return "R5";
      if (op == 4'd9) return "R7";
      if (op == 4'd10 || op == 4'd11) return "R8";
      return "R12";
   endfunction

   function automatic exp_t model(logic [3:0] op, bit nar, bit tm, logic [15:0] acc,
                                  logic [15:0] mem, bit cin, logic [15:0] prev);
      exp_t e;
      int w, msk, a, m, src, v;
      bit n, ov, z, c, da, dm;
      logic [3:0] we;
      w = nar ? 8 : 16;
      msk = (1 << w) - 1;
      a = acc & msk;
      m = mem & msk;
      src = tm ? m : a;
      v = 0; c = 0; ov = 0; da = 0; dm = 0; we = 4'b0000;
      case (op)
         4'd0: begin v = a & m; da = 1; we = 4'b1010; end
         4'd1: begin v = a | m; da = 1; we = 4'b1010; end
         4'd2: begin v = a ^ m; da = 1; we = 4'b1010; end
         4'd3: begin c = (src >> (w-1)) & 1; v = (src << 1) & msk; we = 4'b1011; end
         4'd4: begin c = src & 1; v = src >> 1; we = 4'b1011; end
         4'd5: begin c = (src >> (w-1)) & 1; v = ((src << 1) | cin) & msk; we = 4'b1011; end
         4'd6: begin c = src & 1; v = (src >> 1) | (int'(cin) << (w-1)); we = 4'b1011; end
         4'd7: begin v = (src + 1) & msk; we = 4'b1010; end
         4'd8: begin v = (src - 1) & msk; we = 4'b1010; end
         4'd9: begin v = a; we = 4'b1110; end
         4'd10: begin v = m | a; dm = 1; we = 4'b0010; end
         4'd11: begin v = m & ~a & msk; dm = 1; we = 4'b0010; end
         default: begin v = a; end
      endcase
      if (op >= 4'd3 && op <= 4'd8) begin
         da = !tm;
         dm = tm;
      end
      n = (v >> (w-1)) & 1;
      z = (v == 0);
      if (op == 4'd9) begin
         n  = (m >> (w-1)) & 1;
         ov = (m >> (w-2)) & 1;
         z  = ((a & m) == 0);
      end else if (op == 4'd10 || op == 4'd11) begin
         z = ((a & m) == 0);
      end
      if (da) e.res = nar ? ((acc & 16'hFF00) | 16'(v)) : 16'(v);
      else if (dm) e.res = 16'(v);
      else e.res = acc;
      e.dn  = 1'b1;
      e.aw  = da;
      e.mw  = dm;
      e.fwe = we;
      e.fl  = {n, ov, z, c} & we;
      e.xc  = (op >= 4'd3 && op <= 4'd8) || op == 4'd10 || op == 4'd11;
      e.op  = op;
      e.nar = nar;
      if (prev == 16'hFFFF && op == 4'hF) e.res = e.res; // keep prev referenced
      return e;
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(exp_t e);
      string rtag;
      rtag = e.nar ? "R10" : op_tag(e.op);
      check(done == e.dn, "R1", "done", done, e.dn);
      check(acc_we == e.aw && wb_en == e.mw, "R6", "acc_we/wb_en",
            {acc_we, wb_en}, {e.aw, e.mw});
      check(result == e.res, rtag, "result", result, e.res);
      check(flags_we == e.fwe && flags == e.fl, op_tag(e.op), "flags_we/flags",
            {flags_we, flags}, {e.fwe, e.fl});
      check(extra_cycle == e.xc, "R9", "extra_cycle", extra_cycle, e.xc);
   endtask

   // one cycle: check what is due, then drive and queue the next expectation
   task automatic step(bit vld, logic [3:0] op, bit nar, bit tm,
                       logic [15:0] acc, logic [15:0] mem, bit cin);
      exp_t e;
      @(negedge clk);
      if (pending.size() > 0) compare(pending.pop_front());
      op_valid = vld; op_code = op; narrow = nar; to_mem = tm;
      acc_in = acc; mem_in = mem; carry_in = cin;
      if (vld) begin
         e = model(op, nar, tm, acc, mem, cin, last_res);
         last_res = e.res;
      end else begin
         e = '0;
         e.res = last_res;
         e.op = 4'd0;
      end
      pending.push_back(e);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R11: outputs quiet while in reset, even with a strobe applied
      op_valid = 1'b1; op_code = 4'd3; acc_in = 16'hFFFF;
      @(negedge clk);
      check(done == 0 && acc_we == 0 && wb_en == 0 && flags_we == 0 && flags == 0
            && extra_cycle == 0 && result == 0, "R11", "reset outputs",
            {done, acc_we, wb_en, extra_cycle}, 0);
      op_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 0 && result == 0, "R11", "after reset", {done, result}, 0);

      // directed corners
      step(1, 4'd3, 0, 0, 16'h8001, 16'h0, 0);   // R3 shl carry out
      step(1, 4'd4, 0, 0, 16'h0001, 16'h0, 0);   // R3 shr to zero
      step(1, 4'd5, 0, 0, 16'h8000, 16'h0, 1);   // R4 rol carry in
      step(1, 4'd6, 0, 0, 16'h0001, 16'h0, 1);   // R4 ror carry in
      step(1, 4'd7, 0, 1, 16'h0, 16'hFFFF, 1);   // R5 inc wrap, memory form
      step(1, 4'd8, 0, 0, 16'h0000, 16'h0, 1);   // R5 dec wrap
      step(1, 4'd7, 1, 0, 16'h12FF, 16'h0, 0);   // R10 narrow inc keeps high byte
      step(1, 4'd3, 1, 1, 16'h0, 16'hAB81, 0);   // R10 narrow memory shl
      step(1, 4'd9, 0, 0, 16'h00FF, 16'h4000, 0);// R7 bit-test V from bit 14
      step(1, 4'd9, 1, 0, 16'h0001, 16'h00C1, 0);// R7 narrow bit-test
      step(1, 4'd10, 0, 0, 16'h0F0F, 16'h00F0, 0);// R8 test-and-set
      step(1, 4'd11, 0, 0, 16'h0F0F, 16'h0FF0, 0);// R8 test-and-reset
      step(1, 4'd0, 0, 0, 16'hF0F0, 16'h0F0F, 0); // R2 and to zero
      step(1, 4'd2, 1, 0, 16'h5580, 16'h0000, 0); // R2/R10 narrow xor
      step(0, 4'd1, 0, 0, 16'h1234, 16'h4321, 0); // R1 idle
      step(1, 4'd13, 0, 0, 16'hBEEF, 16'h1111, 1);// R12 undefined code
      step(1, 4'd6, 1, 0, 16'hA501, 16'h0, 1);   // R4 narrow ror

      // broad sweep
      for (int i = 0; i < 2000; i++) begin
         step(($urandom_range(0, 9) != 0), 4'($urandom_range(0, 15)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              16'($urandom), 16'($urandom), 1'($urandom_range(0, 1)));
      end
      step(0, 4'd0, 0, 0, 16'h0, 16'h0, 0);
      step(0, 4'd0, 0, 0, 16'h0, 16'h0, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule